// File: doc/BRIEF.md
# Standby Wake-Up Stabilization Controller

This block manages a low-power standby state for a small processor core. When the core raises a sleep request and the standby-enable input is set, the controller moves to standby. In standby it drops the core clock enable and stalls the core. It then waits for an edge on the non-maskable interrupt pin. A separate select input chooses whether the falling or the rising edge of that pin counts as a wake-up.

When the chosen edge arrives, the controller does not release the core at once. It keeps the core stalled for an oscillator settling interval, which a 3-bit code picks from a fixed set of lengths. When that interval has run out, it restores the clock enable and gives the core a single-cycle resume pulse. The interval timer runs on a free-running reference clock that stays alive through standby.

The wake polarity and the interval code are captured at the moment standby is entered. Changes to those inputs while the core sleeps therefore have no effect until the next entry. The interrupt pin is passed through a two-stage synchronizer before any edge is detected.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `core_clk_en_o` is 1, and `stall_o`, `resume_o` and `cfg_err_o` are 0.
- R2: In idle, a cycle with `sleep_req_i`=1 and `stby_en_i`=1 moves the block to standby (`state_o`=1) at the next clock edge. In standby, `core_clk_en_o` is 0 and `stall_o` is 1.
- R3: In idle, a sleep request with `stby_en_i`=0 leaves the block in idle with the clock enable kept at 1.
- R4: When the captured edge select is 0, a falling edge of `nmi_i` wakes the block from standby, and a rising edge is ignored.
- R5: When the captured edge select is 1, a rising edge of `nmi_i` wakes the block from standby, and a falling edge is ignored.
- R6: After a wake, the block stays in the stabilize state (`state_o`=2) for exactly 2^(BASE_LOG2+c) clock cycles, where c is the captured code 0..5 (8192 to 262144 cycles with the default BASE_LOG2 of 13).
- R7: Code 7 selects a stabilize interval of exactly SHORT_CNT cycles (16 by default).
- R8: Code 6 is reserved. It gives the longest interval, 2^(BASE_LOG2+5) cycles, and sets `cfg_err_o` at entry to standby. `cfg_err_o` then stays at 1 until reset.
- R9: When the stabilize interval ends, the block spends exactly one cycle in resume (`state_o`=3). In that cycle `resume_o`=1, `core_clk_en_o`=1 and `stall_o`=0. The block then returns to idle.
- R10: Edges on `nmi_i` while the block is in idle or stabilize have no effect on the state or on the stabilize length.
- R11: Changes to `stab_sel_i` or `edge_sel_i` while the block is in standby or stabilize do not change the wake polarity or the interval length used.
- R12: If `nmi_i` changes to the wake level before a clock edge k in standby, `state_o` becomes 2 right after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, stays alive in standby |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| sleep_req_i | input | 1 | Sleep request from the core |
| stby_en_i | input | 1 | Enables standby entry on a sleep request |
| edge_sel_i | input | 1 | Wake polarity: 0 falling, 1 rising |
| stab_sel_i | input | 3 | Stabilization interval code |
| nmi_i | input | 1 | Asynchronous non-maskable interrupt pin |
| core_clk_en_o | output | 1 | Clock enable to the core, 0 in standby and stabilize |
| stall_o | output | 1 | Holds the core while asleep or settling |
| resume_o | output | 1 | One-cycle pulse when the core may resume |
| cfg_err_o | output | 1 | Sticky flag: reserved interval code was used |
| state_o | output | 2 | 0 idle, 1 standby, 2 stabilize, 3 resume |

## Verification
The bench builds the controller with BASE_LOG2=3 and SHORT_CNT=4. This gives intervals of 8 to 256 cycles, so every code can be run through to its end, including the reserved one, and the exact count of stabilize cycles can be compared for each code. With these short intervals there is also time to toggle the interrupt pin and the select inputs inside standby and stabilize, and to test both wake polarities back to back. The three-edge latency of the synchronizer is checked edge by edge.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STANDBY = 2'd1,
    ST_STAB    = 2'd2,
    ST_RESUME  = 2'd3
  } stby_state_e;

  localparam logic [2:0] CODE_RSVD  = 3'b110;
  localparam logic [2:0] CODE_SHORT = 3'b111;
  localparam int unsigned LONG_STEP = 5;

  // Number of cycles spent settling for a given interval code.
  function automatic int unsigned wait_len(input logic [2:0] code,
                                           input int unsigned base_log2,
                                           input int unsigned short_cnt);
    int unsigned n;
    if (code == CODE_SHORT) begin
      n = short_cnt;
    end else if (code == CODE_RSVD) begin
      n = 32'd1 << (base_log2 + LONG_STEP);
    end else begin
      n = 32'd1 << (base_log2 + {29'd0, code});
    end
    return n;
  endfunction

endpackage

// File: rtl/stby_nmi_edge.sv
module stby_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic rise_sel_i,
  output logic wake_edge_o
);

  logic sync1_q, sync2_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      sync1_q <= nmi_i;
      sync2_q <= sync1_q;
      last_q  <= sync2_q;
    end
  end

  logic rise_seen, fall_seen;

  always_comb begin
    rise_seen   = sync2_q & ~last_q;
    fall_seen   = ~sync2_q & last_q;
    wake_edge_o = rise_sel_i ? rise_seen : fall_seen;
  end

endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer #(
  parameter int unsigned W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 13,
  parameter int unsigned SHORT_CNT = 16,
  parameter int unsigned CNT_W     = BASE_LOG2 + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req_i,
  input  logic             stby_en_i,
  input  logic             edge_sel_i,
  input  logic [2:0]       stab_sel_i,
  input  logic             wake_edge_i,
  input  logic             timer_zero_i,
  output stby_state_e      state_o,
  output logic             rise_sel_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             run_o,
  output logic             cfg_err_o
);

  stby_state_e state_q, state_d;
  logic        pol_q;
  logic [2:0]  code_q;
  logic        err_q;
  logic        enter;

  // next-state logic
  always_comb begin
    state_d = state_q;
    enter   = 1'b0;
    load_o  = 1'b0;
    run_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_req_i && stby_en_i) begin
          enter   = 1'b1;
          state_d = ST_STANDBY;
        end
      end
      ST_STANDBY: begin
        if (wake_edge_i) begin
          load_o  = 1'b1;
          state_d = ST_STAB;
        end
      end
      ST_STAB: begin
        run_o = 1'b1;
        if (timer_zero_i) begin
          state_d = ST_RESUME;
        end
      end
      ST_RESUME: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // configuration captured on entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      code_q <= 3'd0;
    end else if (enter) begin
      pol_q  <= edge_sel_i;
      code_q <= stab_sel_i;
    end
  end

  // sticky reserved-code flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (enter && (stab_sel_i == CODE_RSVD)) begin
      err_q <= 1'b1;
    end
  end

  assign load_val_o = CNT_W'(wait_len(code_q, BASE_LOG2, SHORT_CNT) - 32'd1);
  assign state_o    = state_q;
  assign rise_sel_o = pol_q;
  assign cfg_err_o  = err_q;

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 13,
  parameter int unsigned SHORT_CNT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req_i,
  input  logic       stby_en_i,
  input  logic       edge_sel_i,
  input  logic [2:0] stab_sel_i,
  input  logic       nmi_i,
  output logic       core_clk_en_o,
  output logic       stall_o,
  output logic       resume_o,
  output logic       cfg_err_o,
  output logic [1:0] state_o
);

  localparam int unsigned CNT_W = BASE_LOG2 + 6;

  stby_state_e      state;
  logic             rise_sel;
  logic             wake_edge;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             run;
  logic             timer_zero;

  stby_nmi_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .nmi_i       (nmi_i),
    .rise_sel_i  (rise_sel),
    .wake_edge_o (wake_edge)
  );

  stby_stab_timer #(.W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .run_i      (run),
    .zero_o     (timer_zero)
  );

  stby_fsm #(
    .BASE_LOG2 (BASE_LOG2),
    .SHORT_CNT (SHORT_CNT),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req_i  (sleep_req_i),
    .stby_en_i    (stby_en_i),
    .edge_sel_i   (edge_sel_i),
    .stab_sel_i   (stab_sel_i),
    .wake_edge_i  (wake_edge),
    .timer_zero_i (timer_zero),
    .state_o      (state),
    .rise_sel_o   (rise_sel),
    .load_o       (load),
    .load_val_o   (load_val),
    .run_o        (run),
    .cfg_err_o    (cfg_err_o)
  );

  always_comb begin
    core_clk_en_o = (state == ST_IDLE) || (state == ST_RESUME);
    stall_o       = (state == ST_STANDBY) || (state == ST_STAB);
    resume_o      = (state == ST_RESUME);
  end

  assign state_o = state;

endmodule

// File: rtl/stby_wake_chk.sv
module stby_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req_i,
  input logic       stby_en_i,
  input logic       core_clk_en_o,
  input logic       stall_o,
  input logic       resume_o,
  input logic       cfg_err_o,
  input logic [1:0] state_o
);

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && sleep_req_i && stby_en_i) |=> (state_o == 2'd1));

  p_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |-> (!core_clk_en_o && stall_o));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !(sleep_req_i && stby_en_i)) |=> (state_o == 2'd0 && core_clk_en_o));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);

  p_resume_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> (!resume_o && state_o == 2'd0));

  p_stab_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> (state_o == 2'd2 || (resume_o && core_clk_en_o && !stall_o)));

endmodule

bind stby_wake_ctrl stby_wake_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_req_i   (sleep_req_i),
  .stby_en_i     (stby_en_i),
  .core_clk_en_o (core_clk_en_o),
  .stall_o       (stall_o),
  .resume_o      (resume_o),
  .cfg_err_o     (cfg_err_o),
  .state_o       (state_o)
);

// File: tb/tb_stby_wake_ctrl.sv
`timescale 1ns/1ps
module tb_stby_wake_ctrl;

  localparam int BASE = 3;
  localparam int SHORT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_req_i, stby_en_i, edge_sel_i, nmi_i;
  logic [2:0] stab_sel_i;
  logic       core_clk_en_o, stall_o, resume_o, cfg_err_o;
  logic [1:0] state_o;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stby_wake_ctrl #(.BASE_LOG2(BASE), .SHORT_CNT(SHORT)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i), .stby_en_i(stby_en_i),
    .edge_sel_i(edge_sel_i), .stab_sel_i(stab_sel_i), .nmi_i(nmi_i),
    .core_clk_en_o(core_clk_en_o), .stall_o(stall_o), .resume_o(resume_o),
    .cfg_err_o(cfg_err_o), .state_o(state_o)
  );

  function automatic int exp_len(input int code);
    if (code == 7) return SHORT;
    if (code == 6) return 1 << (BASE + 5);
    return 1 << (BASE + code);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st, m_rem, m_pol, m_code, m_err;
  int hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_err = 0; m_pol = 0; m_code = 0;
      hist = '{0, 0, 0, 0};
    end else begin
      bit rose, fell;
      hist.push_front(int'(nmi_i));
      void'(hist.pop_back());
      rose = (hist[3] == 0) && (hist[2] == 1);
      fell = (hist[3] == 1) && (hist[2] == 0);
      case (m_st)
        0: if (sleep_req_i && stby_en_i) begin
             m_st = 1; m_pol = int'(edge_sel_i); m_code = int'(stab_sel_i);
             if (stab_sel_i == 3'd6) m_err = 1;
           end
        1: if ((m_pol == 1) ? rose : fell) begin
             m_st = 2; m_rem = exp_len(m_code) - 1;
           end
        2: if (m_rem == 0) m_st = 3; else m_rem--;
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(state_o) == m_st, "R2", "model state", int'(state_o), m_st);
      chk(int'(core_clk_en_o) == int'(m_st == 0 || m_st == 3), "R9", "model clk_en",
          int'(core_clk_en_o), int'(m_st == 0 || m_st == 3));
      chk(int'(stall_o) == int'(m_st == 1 || m_st == 2), "R2", "model stall",
          int'(stall_o), int'(m_st == 1 || m_st == 2));
      chk(int'(resume_o) == int'(m_st == 3), "R9", "model resume",
          int'(resume_o), int'(m_st == 3));
      chk(int'(cfg_err_o) == m_err, "R8", "model cfg_err", int'(cfg_err_o), m_err);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_case(input int code, input bit sel, input string ltag);
    int n;
    nmi_i = sel; stab_sel_i = 3'(code); edge_sel_i = sel;
    repeat (5) @(negedge clk);
    sleep_req_i = 1; stby_en_i = 1;
    @(negedge clk);
    sleep_req_i = 0;
    chk(state_o == 2'd1, "R2", "entered standby", int'(state_o), 1);
    chk(core_clk_en_o == 1'b0, "R2", "clk_en in standby", int'(core_clk_en_o), 0);
    // R11: change config during standby
    stab_sel_i = (code == 7) ? 3'd0 : 3'd7;
    edge_sel_i = ~sel;
    nmi_i = ~sel;                       // wrong polarity edge
    repeat (6) @(negedge clk);
    chk(state_o == 2'd1, sel ? "R5" : "R4", "wrong edge ignored", int'(state_o), 1);
    nmi_i = sel;                        // wake edge
    @(negedge clk);
    chk(state_o == 2'd1, "R12", "sync stage 1", int'(state_o), 1);
    @(negedge clk);
    chk(state_o == 2'd1, "R12", "sync stage 2", int'(state_o), 1);
    @(negedge clk);
    chk(state_o == 2'd2, "R12", "stabilize after third edge", int'(state_o), 2);
    n = 1;
    forever begin
      if (n == 2) nmi_i = ~sel;         // R10: edges during stabilize
      if (n == 4) nmi_i = sel;
      @(negedge clk);
      if (state_o == 2'd2) n++;
      else break;
    end
    chk(n == exp_len(code), ltag, "stabilize length", n, exp_len(code));
    chk(resume_o == 1'b1 && state_o == 2'd3, "R9", "resume pulse", int'(resume_o), 1);
    chk(core_clk_en_o == 1'b1 && stall_o == 1'b0, "R9", "released in resume",
        int'(core_clk_en_o), 1);
    @(negedge clk);
    chk(resume_o == 1'b0 && state_o == 2'd0, "R9", "back to idle", int'(state_o), 0);
  endtask

  initial begin
    rst_n = 0; sleep_req_i = 0; stby_en_i = 0; edge_sel_i = 0; nmi_i = 0; stab_sel_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(state_o == 2'd0 && core_clk_en_o && !stall_o && !resume_o && !cfg_err_o,
        "R1", "reset state", int'(state_o), 0);

    // R3: request without enable
    sleep_req_i = 1; stby_en_i = 0;
    @(negedge clk);
    sleep_req_i = 0;
    @(negedge clk);
    chk(state_o == 2'd0 && core_clk_en_o, "R3", "no entry without enable", int'(state_o), 0);

    // R10: pin edges in idle
    nmi_i = 1; repeat (4) @(negedge clk);
    nmi_i = 0; repeat (4) @(negedge clk);
    chk(state_o == 2'd0, "R10", "idle ignores pin", int'(state_o), 0);

    for (int c = 0; c < 6; c++) run_case(c, c[0], "R6");
    run_case(7, 1'b0, "R7");
    run_case(7, 1'b1, "R7");
    chk(cfg_err_o == 1'b0, "R8", "no error for valid codes", int'(cfg_err_o), 0);
    run_case(6, 1'b1, "R8");
    chk(cfg_err_o == 1'b1, "R8", "error after reserved code", int'(cfg_err_o), 1);
    run_case(7, 1'b0, "R7");
    chk(cfg_err_o == 1'b1, "R8", "error sticky", int'(cfg_err_o), 1);

    do_reset();
    @(negedge clk);
    chk(cfg_err_o == 1'b0 && state_o == 2'd0, "R1", "reset clears error", int'(cfg_err_o), 0);
    run_case(3, 1'b0, "R11");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule